// File: doc/BRIEF.md
# Infrared Carrier Generator with Auto-Gating Timer

This block drives the carrier pin of an infrared remote-control transmitter. It runs from the master oscillator clock. A 3-bit select code divides that clock by 1, 4, 8, 12, 64 or 96, or holds the pin steadily high. The pin is always driven to a definite 0 or 1. Every high pulse of a divided carrier has its full length. The gate that enables the carrier may change only while the carrier is low, or on the edge that ends a high half-period.

An 8-bit down-counter with its own reload register runs beside the divider. Each underflow reloads the counter and sets a sticky flag, which software clears by writing a 1 to it. When auto-control is enabled, each underflow also toggles an automatic gate. That gate then replaces the software enable bit, so marks and spaces of equal length form without CPU help. Register writes are single-cycle write strobes, each with its own data.

Top module: `ir_carrier_gen`

## Requirements
- R1: Select codes 1, 2, 3, 4 and 5 produce a square wave whose half-period is 2, 4, 6, 32 and 48 clocks. After a select write the carrier is low for one half-period, then high for one half-period.
- R2: Select code 0 (the reset value) outputs the clock ANDed with the enable, where the enable is sampled on the falling clock edge.
- R3: Select codes 6 and 7 hold the carrier at the enable value. A change of the enable reaches the pin two clocks after the write strobe.
- R4: With auto-control off, bit 3 of the 4-bit control write is the carrier enable. Bits 0 to 2 have no effect.
- R5: With the divider running, a gate change that arrives during a high half-period takes effect only after that half-period ends.
- R6: A timer write with the start bit set loads the counter from the reload value. If the reload value is written in the same cycle, the new value is used. The counter then decrements once per clock and underflows once every reload+1 clocks, reloading on each underflow.
- R7: A reload write while the timer runs does not disturb the current count. It takes effect at the next underflow.
- R8: The underflow flag sets on underflow and stays set. A flag write with data 1 clears it, a flag write with data 0 has no effect, and a new underflow wins over a clear in the same cycle.
- R9: With auto-control on, each underflow toggles the automatic gate and the control-register enable is ignored. A start write clears the automatic gate.
- R10: Reset drives the carrier low, clears the flag and the enable, selects code 0 and stops the timer.
- R11: A timer write with the start bit clear stops the count, and no further underflow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Select register write strobe; restarts the divider |
| cfg_sel_i | input | 3 | Carrier select code |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wd_i | input | 4 | Control write data; bit 3 is the carrier enable |
| rld_we_i | input | 1 | Reload register write strobe |
| rld_wd_i | input | 8 | Reload value |
| tmr_we_i | input | 1 | Timer control write strobe |
| tmr_start_i | input | 1 | Start bit (1 = load and run, 0 = stop) |
| tmr_auto_i | input | 1 | Auto-control enable |
| flg_we_i | input | 1 | Flag write strobe |
| flg_wd_i | input | 1 | Flag write data; 1 clears |
| carr_o | output | 1 | Carrier output |
| tmr_uf_o | output | 1 | Sticky underflow flag |

## Verification
Every divided select code is swept over four half-periods, and the carrier is compared each clock against the arithmetic square wave. This separates the half-period lengths from one another and from a wrong starting phase. The clock-pass code is sampled on both clock levels, and the fixed-high codes are sampled around enable writes, to catch wrong latency. Two experiments cover the timer. In the first, the enable is dropped in mid-pulse to expose a truncated pulse, and two different reload values are used with one of them written mid-count. In the second, the auto-gated carrier is compared with the expected mark/space pattern, including a restart in mid-burst.

// File: rtl/ir_carr_pkg.sv
package ir_carr_pkg;
  localparam int unsigned HALF_W = 6;

  typedef enum logic [2:0] {
    SEL_DIV1  = 3'd0,
    SEL_DIV4  = 3'd1,
    SEL_DIV8  = 3'd2,
    SEL_DIV12 = 3'd3,
    SEL_DIV64 = 3'd4,
    SEL_DIV96 = 3'd5,
    SEL_HIGH  = 3'd6,
    SEL_HIGH2 = 3'd7
  } carr_sel_e;

  // half-period length in clocks; 1 for non-dividing codes
  function automatic logic [HALF_W-1:0] half_of(carr_sel_e s);
    logic [HALF_W-1:0] h;
    case (s)
      SEL_DIV4:  h = HALF_W'(2);
      SEL_DIV8:  h = HALF_W'(4);
      SEL_DIV12: h = HALF_W'(6);
      SEL_DIV64: h = HALF_W'(32);
      SEL_DIV96: h = HALF_W'(48);
      default:   h = HALF_W'(1);
    endcase
    return h;
  endfunction
endpackage

// File: rtl/ir_carr_div.sv
module ir_carr_div #(
  parameter int unsigned HALF_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              ph_o,
  output logic              last_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              ph_q;

  assign last_o = (cnt_q == half_i - 1'b1);
  assign ph_o   = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (last_o) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < half_i); // R1
  AST_PH_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!last_o && !restart_i) |=> $stable(ph_q)); // R1
endmodule

// File: rtl/ir_carr_tmr.sv
module ir_carr_tmr #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rld_we_i,
  input  logic [TMR_W-1:0] rld_wd_i,
  input  logic             start_we_i,
  input  logic             start_i,
  output logic             uf_o
);
  logic [TMR_W-1:0] reload_q;
  logic [TMR_W-1:0] cnt_q;
  logic             run_q;
  logic [TMR_W-1:0] load_val;

  assign load_val = rld_we_i ? rld_wd_i : reload_q;
  assign uf_o     = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reload_q <= '0;
    else if (rld_we_i) reload_q <= rld_wd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_we_i) begin
      run_q <= start_i;
      if (start_i) cnt_q <= load_val;
    end else if (run_q) begin
      cnt_q <= uf_o ? reload_q : cnt_q - 1'b1;
    end
  end

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_o && !start_we_i) |=> (cnt_q == $past(reload_q))); // R6
  AST_COUNT_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !uf_o && !start_we_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7
  AST_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_we_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/ir_carr_gate.sv
module ir_carr_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_div1_i,
  input  logic mode_high_i,
  input  logic ph_i,
  input  logic last_i,
  input  logic uf_i,
  input  logic start_i,
  input  logic auto_i,
  input  logic oe_i,
  output logic carr_o
);
  logic agate_q;
  logic gate_q;
  logic g1_q;
  logic src;
  logic upd;

  assign src = auto_i ? agate_q : oe_i;
  // safe to move the gate while low or on the edge closing a high half
  assign upd = mode_div1_i | mode_high_i | ~ph_i | last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) agate_q <= 1'b0;
    else if (start_i) agate_q <= 1'b0;
    else if (uf_i) agate_q <= ~agate_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else if (upd) gate_q <= src;
  end

  // divide-by-1 enable moves only while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) g1_q <= 1'b0;
    else g1_q <= src;
  end

  always_comb begin
    if (mode_high_i)      carr_o = gate_q;
    else if (mode_div1_i) carr_o = clk_i & g1_q;
    else                  carr_o = ph_i & gate_q;
  end

  AST_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_div1_i && !mode_high_i && ph_i && !last_i) |=> $stable(gate_q)); // R5
  AST_HIGH_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_high_i |=> (gate_q == $past(src))); // R3
  AST_AUTO_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_i && !start_i) |=> (agate_q != $past(agate_q))); // R9
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carr_pkg::*;
#(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned CTL_W  = 4,
  parameter int unsigned OE_BIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_sel_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wd_i,
  input  logic             rld_we_i,
  input  logic [TMR_W-1:0] rld_wd_i,
  input  logic             tmr_we_i,
  input  logic             tmr_start_i,
  input  logic             tmr_auto_i,
  input  logic             flg_we_i,
  input  logic             flg_wd_i,
  output logic             carr_o,
  output logic             tmr_uf_o
);
  carr_sel_e         sel_q;
  logic              oe_q;
  logic              auto_q;
  logic              flag_q;
  logic              uf;
  logic              ph;
  logic              last;
  logic              mode_div1;
  logic              mode_high;
  logic [HALF_W-1:0] half;
  logic              ctl_unused;

  assign ctl_unused = ^ctl_wd_i[OE_BIT-1:0];
  assign mode_div1  = (sel_q == SEL_DIV1);
  assign mode_high  = (sel_q == SEL_HIGH) || (sel_q == SEL_HIGH2);
  assign half       = half_of(sel_q);
  assign tmr_uf_o   = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_DIV1;
      oe_q   <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      if (cfg_we_i) sel_q  <= carr_sel_e'(cfg_sel_i);
      if (ctl_we_i) oe_q   <= ctl_wd_i[OE_BIT];
      if (tmr_we_i) auto_q <= tmr_auto_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (uf) flag_q <= 1'b1;
    else if (flg_we_i && flg_wd_i) flag_q <= 1'b0;
  end

  ir_carr_div #(.HALF_W(HALF_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (cfg_we_i),
    .half_i    (half),
    .ph_o      (ph),
    .last_o    (last)
  );

  ir_carr_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rld_we_i   (rld_we_i),
    .rld_wd_i   (rld_wd_i),
    .start_we_i (tmr_we_i),
    .start_i    (tmr_start_i),
    .uf_o       (uf)
  );

  ir_carr_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_div1_i (mode_div1),
    .mode_high_i (mode_high),
    .ph_i        (ph),
    .last_i      (last),
    .uf_i        (uf),
    .start_i     (tmr_we_i & tmr_start_i),
    .auto_i      (auto_q),
    .oe_i        (oe_q),
    .carr_o      (carr_o)
  );

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf |=> tmr_uf_o); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_uf_o && !(flg_we_i && flg_wd_i)) |=> tmr_uf_o); // R8
endmodule

// File: tb/ir_carrier_gen_test.sv
module ir_carrier_gen_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       cfg_we = 0, ctl_we = 0, rld_we = 0, tmr_we = 0;
  logic       tmr_start = 0, tmr_auto = 0, flg_we = 0, flg_wd = 0;
  logic [2:0] cfg_sel = 0;
  logic [3:0] ctl_wd = 0;
  logic [7:0] rld_wd = 0;
  logic       carr, uf;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  ir_carrier_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .ctl_we_i(ctl_we), .ctl_wd_i(ctl_wd), .rld_we_i(rld_we), .rld_wd_i(rld_wd),
    .tmr_we_i(tmr_we), .tmr_start_i(tmr_start), .tmr_auto_i(tmr_auto),
    .flg_we_i(flg_we), .flg_wd_i(flg_wd), .carr_o(carr), .tmr_uf_o(uf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic set_sel(input int code);
    cfg_we = 1; cfg_sel = 3'(code); step(); cfg_we = 0;
  endtask

  task automatic set_ctl(input logic [3:0] v);
    ctl_we = 1; ctl_wd = v; step(); ctl_we = 0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int halves[5] = '{2, 4, 6, 32, 48};
    #1 rst_ni = 1'b0;
    #20;
    chk("R10 carrier in reset", carr, 0);
    chk("R10 flag in reset", uf, 0);
    rst_ni = 1'b1;
    step();
    chk("R10 carrier after reset", carr, 0);

    // R2: clock pass-through
    set_ctl(4'b1000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1; chk("R2 low half", carr, 0);
      @(posedge clk); #1; chk("R2 high half", carr, 1);
    end
    // R4: bits 0..2 do not enable
    set_ctl(4'b0111);
    step(); chk("R4 low bits ignored", carr, 0);
    step(); chk("R4 low bits ignored", carr, 0);
    set_ctl(4'b1000);
    step();

    // R1: divider sweep
    for (int c = 1; c <= 5; c++) begin
      int h = halves[c-1];
      set_sel(c);
      chk($sformatf("R1 code %0d k=0", c), carr, 0);
      for (int k = 1; k <= 4*h; k++) begin
        step();
        chk($sformatf("R1 code %0d k=%0d", c, k), carr, (k / h) % 2);
      end
    end

    // R5: enable dropped mid-pulse (half-period 4)
    set_sel(2);
    for (int k = 1; k <= 16; k++) begin
      if (k == 5) begin ctl_we = 1; ctl_wd = 4'b0000; end
      step();
      ctl_we = 0;
      chk($sformatf("R5 k=%0d", k), carr, (k >= 4 && k <= 7) ? 1 : 0);
    end

    // R3: fixed high codes
    set_sel(6);
    chk("R3 code 6 off", carr, 0);
    set_ctl(4'b1000);
    chk("R3 latency", carr, 0);
    step(); chk("R3 code 6 on", carr, 1);
    set_sel(7);
    chk("R3 code 7 on", carr, 1);
    set_ctl(4'b0000);
    chk("R3 code 7 latency", carr, 1);
    step(); chk("R3 code 7 off", carr, 0);
    set_sel(6);

    // R6/R8/R7: timer, reload 5 written with start
    tmr_we = 1; tmr_start = 1; tmr_auto = 0; rld_we = 1; rld_wd = 8'd5;
    step();
    tmr_we = 0; rld_we = 0;
    for (int k = 1; k <= 6; k++) begin
      step();
      if (k == 1 || k == 5) chk($sformatf("R6 no underflow k=%0d", k), uf, 0);
      if (k == 6) chk("R6 underflow at reload+1", uf, 1);
    end
    flg_we = 1; flg_wd = 0; step(); flg_we = 0;      // k=7
    chk("R8 write 0 ignored", uf, 1);
    flg_we = 1; flg_wd = 1; rld_we = 1; rld_wd = 8'd9;
    step(); flg_we = 0; rld_we = 0;                   // k=8
    chk("R8 write 1 clears", uf, 0);
    for (int k = 9; k <= 22; k++) begin
      if (k == 13) begin flg_we = 1; flg_wd = 1; end
      step();
      flg_we = 0;
      if (k == 11) chk("R7 old count kept", uf, 0);
      if (k == 12) chk("R7 underflow on old count", uf, 1);
      if (k == 13) chk("R8 clear again", uf, 0);
      if (k == 21) chk("R7 new period not yet", uf, 0);
      if (k == 22) chk("R7 new period", uf, 1);
    end

    // R11: stop
    tmr_we = 1; tmr_start = 0; flg_we = 1; flg_wd = 1;
    step(); tmr_we = 0; flg_we = 0;
    repeat (40) step();
    chk("R11 stopped timer silent", uf, 0);

    // R9: auto gating, observed in fixed-high mode with enable set
    set_ctl(4'b1000);
    step();
    tmr_we = 1; tmr_start = 1; tmr_auto = 1; rld_we = 1; rld_wd = 8'd3;
    step();
    tmr_we = 0; rld_we = 0;
    for (int k = 1; k <= 6; k++) begin
      step();
      chk($sformatf("R9 auto k=%0d", k), carr, ((k - 1) / 4) % 2);
    end
    tmr_we = 1; tmr_start = 1; tmr_auto = 1;
    step(); tmr_we = 0;
    chk("R9 restart m=0", carr, 1);
    for (int m = 1; m <= 5; m++) begin
      step();
      chk($sformatf("R9 restart m=%0d", m), carr, (m == 5) ? 1 : 0);
    end

    finish_run();
  end
endmodule